// File: doc/BRIEF.md
# Dual-Channel Converter Output Controller

This block takes two corrected sample streams, channel A and channel B, one code per clock each, and delivers them on a registered parallel output port. Both channels pass through pipelines of equal depth. Their words therefore change together on the same rising clock edge, a fixed number of edges after they are captured. A single format-select input applies to both channels. It chooses between plain offset binary and two's complement, which is made by inverting the top bit.

A low-power request (`doze`) and a full shut-off request (`power_off`) both stall the block. While either is active, no new samples enter, every stage keeps its contents and the output words stay frozen at their last value. The qualifier `words_valid` is cleared and stays low until a full pipeline of fresh samples has arrived. The output port is modelled as a data bus plus a per-bit drive enable. The enable follows the active-high `drive_off` input with no clock in the path, so a downstream pad ring can float the bus at once.

Top module: `dual_adc_out_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, both output words are cleared to zero and `words_valid` is low after that edge.
- R2: A code present on `ch_a_code` and `ch_b_code` at a run edge (neither `doze` nor `power_off` high) appears on `bus_a` and `bus_b` after the LAT-th following run edge (LAT = 5 by default). Both channels update on the same edge.
- R3: With `fmt_signed` low (offset binary), the output word equals the input code.
- R4: With `fmt_signed` high (two's complement), the output word equals (code − 2^(W−1)) modulo 2^W. For W = 10 this maps 0→0x200, 511→0x3FF, 512→0x000 and 1023→0x1FF. The format level that counts is the one present at the edge that loads the word into the output register, and it applies to both channels.
- R5: `bus_a_en` and `bus_b_en` are all zeros (bus floating) whenever `drive_off` is high and all ones whenever it is low. A change takes effect without waiting for a clock edge.
- R6: At an edge where `power_off` is high, no input code is captured and both output words keep their value. `words_valid` is low after that edge.
- R7: At an edge where `doze` is high, the block behaves as in R6: no capture, words held, `words_valid` low after the edge. The bus enable still follows `drive_off`.
- R8: After reset or after any stall, `words_valid` stays low through the first LAT run edges. It rises at the (LAT+1)-th consecutive run edge, which delivers the first freshly captured sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; rising edge captures and updates |
| rst | input | 1 | Synchronous active-high reset |
| ch_a_code | input | W | Channel A offset-binary code |
| ch_b_code | input | W | Channel B offset-binary code |
| fmt_signed | input | 1 | 1: two's complement, 0: offset binary (both channels) |
| drive_off | input | 1 | 1: output bus floats (enables low) |
| doze | input | 1 | Low-power stall request |
| power_off | input | 1 | Full shut-off stall request, holds the last words |
| bus_a | output | W | Channel A output word |
| bus_b | output | W | Channel B output word |
| bus_a_en | output | W | Per-bit drive enable for channel A |
| bus_b_en | output | W | Per-bit drive enable for channel B |
| words_valid | output | 1 | Output words carry fresh samples |

## Verification
The bench builds the block with its defaults, W = 10 and LAT = 5. The code space then has only 1024 values, so every code is swept through both channels in both formats. Channel B gets the mirrored code, which puts both ends of the range and the midpoint codes 511 and 512 on the bus in each format. The short pipeline lets stall pulses of either kind, a format change on every edge, and the LAT-edge recovery of the valid flag all be covered in a few dozen cycles each.

// File: rtl/aoc_pkg.sv
package aoc_pkg;
  localparam int AOC_NCH = 2;

  typedef enum logic {
    FMT_OFFSET = 1'b0,
    FMT_TWOS   = 1'b1
  } aoc_fmt_e;

  typedef enum int {
    CH_A = 0,
    CH_B = 1
  } aoc_ch_e;
endpackage

// File: rtl/aoc_fmt_conv.sv
module aoc_fmt_conv #(
  parameter int W = 10
) (
  input  aoc_pkg::aoc_fmt_e fmt,
  input  logic [W-1:0]      code_in,
  output logic [W-1:0]      code_out
);
  // Two's complement of an offset code: subtracting half scale
  // modulo 2^W is the same as flipping the top bit.
  always_comb begin
    code_out = code_in;
    if (fmt == aoc_pkg::FMT_TWOS) begin
      code_out[W-1] = ~code_in[W-1];
    end
  end
endmodule

// File: rtl/aoc_lane.sv
module aoc_lane #(
  parameter int W   = 10,
  parameter int LAT = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  input  logic         fmt_signed,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam int LAST = LAT - 1;

  logic [W-1:0] stg [LAT];
  logic [W-1:0] conv_word;
  aoc_pkg::aoc_fmt_e fmt_sel;

  assign fmt_sel = fmt_signed ? aoc_pkg::FMT_TWOS : aoc_pkg::FMT_OFFSET;

  // Capture stage plus LAT-1 delay stages; all stall together on !adv.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LAT; i++) stg[i] <= '0;
    end else if (adv) begin
      stg[0] <= din;
      for (int i = 1; i < LAT; i++) stg[i] <= stg[i-1];
    end
  end

  aoc_fmt_conv #(.W(W)) conv_i (
    .fmt      (fmt_sel),
    .code_in  (stg[LAST]),
    .code_out (conv_word)
  );

  // Output register: format applied on the load edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      dout <= '0;
    end else if (adv) begin
      dout <= conv_word;
    end
  end
endmodule

// File: rtl/aoc_run_ctrl.sv
module aoc_run_ctrl #(
  parameter int LAT = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic doze,
  input  logic power_off,
  output logic adv,
  output logic fresh_valid
);
  localparam int CW = $clog2(LAT + 1);
  localparam logic [CW-1:0] FULL = CW'(LAT);

  logic [CW-1:0] fill_cnt;

  assign adv = ~(doze | power_off);

  // fill_cnt counts run edges since the last stall, saturating at LAT.
  always_ff @(posedge clk) begin
    if (rst) begin
      fill_cnt    <= '0;
      fresh_valid <= 1'b0;
    end else if (!adv) begin
      fill_cnt    <= '0;
      fresh_valid <= 1'b0;
    end else begin
      fresh_valid <= (fill_cnt >= FULL);
      if (fill_cnt < FULL) fill_cnt <= fill_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/aoc_bus_enable.sv
module aoc_bus_enable #(
  parameter int W = 10
) (
  input  logic         drive_off,
  output logic [W-1:0] en
);
  assign en = {W{~drive_off}};
endmodule

// File: rtl/dual_adc_out_ctrl.sv
module dual_adc_out_ctrl #(
  parameter int W   = 10,
  parameter int LAT = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] ch_a_code,
  input  logic [W-1:0] ch_b_code,
  input  logic         fmt_signed,
  input  logic         drive_off,
  input  logic         doze,
  input  logic         power_off,
  output logic [W-1:0] bus_a,
  output logic [W-1:0] bus_b,
  output logic [W-1:0] bus_a_en,
  output logic [W-1:0] bus_b_en,
  output logic         words_valid
);
  localparam int NCH = aoc_pkg::AOC_NCH;

  logic         adv;
  logic [W-1:0] lane_in  [NCH];
  logic [W-1:0] lane_out [NCH];
  logic [W-1:0] lane_en  [NCH];

  assign lane_in[aoc_pkg::CH_A] = ch_a_code;
  assign lane_in[aoc_pkg::CH_B] = ch_b_code;

  aoc_run_ctrl #(.LAT(LAT)) run_i (
    .clk         (clk),
    .rst         (rst),
    .doze        (doze),
    .power_off   (power_off),
    .adv         (adv),
    .fresh_valid (words_valid)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_lane
    aoc_lane #(.W(W), .LAT(LAT)) lane_i (
      .clk        (clk),
      .rst        (rst),
      .adv        (adv),
      .fmt_signed (fmt_signed),
      .din        (lane_in[ch]),
      .dout       (lane_out[ch])
    );
    aoc_bus_enable #(.W(W)) en_i (
      .drive_off (drive_off),
      .en        (lane_en[ch])
    );
  end

  assign bus_a    = lane_out[aoc_pkg::CH_A];
  assign bus_b    = lane_out[aoc_pkg::CH_B];
  assign bus_a_en = lane_en[aoc_pkg::CH_A];
  assign bus_b_en = lane_en[aoc_pkg::CH_B];
endmodule

// File: rtl/dual_adc_out_ctrl_chk.sv
module dual_adc_out_ctrl_chk #(
  parameter int W = 10
) (
  input logic         clk,
  input logic         rst,
  input logic         drive_off,
  input logic         doze,
  input logic         power_off,
  input logic [W-1:0] bus_a,
  input logic [W-1:0] bus_b,
  input logic [W-1:0] bus_a_en,
  input logic [W-1:0] bus_b_en,
  input logic         words_valid
);
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!words_valid && bus_a == '0 && bus_b == '0)); // R1

  AST_FLOAT_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    drive_off |-> (bus_a_en == '0 && bus_b_en == '0)); // R5

  AST_DRIVE_WHEN_ON: assert property (@(posedge clk) disable iff (rst)
    !drive_off |-> (&bus_a_en && &bus_b_en)); // R5

  AST_POWER_OFF_HOLDS: assert property (@(posedge clk) disable iff (rst)
    power_off |=> ($stable(bus_a) && $stable(bus_b) && !words_valid)); // R6

  AST_DOZE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    doze |=> ($stable(bus_a) && $stable(bus_b) && !words_valid)); // R7

  AST_VALID_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
    $rose(words_valid) |-> $past(!(doze || power_off))); // R8
endmodule

bind dual_adc_out_ctrl dual_adc_out_ctrl_chk #(.W(W)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .drive_off   (drive_off),
  .doze        (doze),
  .power_off   (power_off),
  .bus_a       (bus_a),
  .bus_b       (bus_b),
  .bus_a_en    (bus_a_en),
  .bus_b_en    (bus_b_en),
  .words_valid (words_valid)
);

// File: tb/dual_adc_out_ctrl_tb_top.sv
module dual_adc_out_ctrl_tb_top;
  localparam int W    = 10;
  localparam int LAT  = 5;
  localparam int FS   = 1 << W;
  localparam int HALF = 1 << (W - 1);
  localparam int HD   = 4096;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] ch_a_code = '0;
  logic [W-1:0] ch_b_code = '0;
  logic         fmt_signed = 1'b0;
  logic         drive_off = 1'b0;
  logic         doze = 1'b0;
  logic         power_off = 1'b0;
  logic [W-1:0] bus_a, bus_b, bus_a_en, bus_b_en;
  logic         words_valid;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // Bench model state: history of captured codes indexed by run-edge count.
  int hist_a [HD];
  int hist_b [HD];
  int run_cnt = 0;
  int fresh   = 0;
  int exp_a   = 0;
  int exp_b   = 0;
  bit exp_v   = 1'b0;

  always #2.5 clk = ~clk;

  dual_adc_out_ctrl #(.W(W), .LAT(LAT)) dut_i (
    .clk(clk), .rst(rst), .ch_a_code(ch_a_code), .ch_b_code(ch_b_code),
    .fmt_signed(fmt_signed), .drive_off(drive_off), .doze(doze),
    .power_off(power_off), .bus_a(bus_a), .bus_b(bus_b),
    .bus_a_en(bus_a_en), .bus_b_en(bus_b_en), .words_valid(words_valid)
  );

  function automatic int to_fmt(input int code, input bit twos);
    return twos ? ((code - HALF + FS) % FS) : code;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  task automatic check_en(input string tag);
    int want;
    want = drive_off ? 0 : FS - 1;
    check(int'(bus_a_en) == want && int'(bus_b_en) == want, tag,
          int'({bus_a_en, bus_b_en}), (want << W) | want);
  endtask

  // Called at a negedge: apply inputs, take one edge, update model, compare.
  task automatic step(input int a, input int b, input bit f, input bit dz,
                      input bit po, input bit off, input string tag);
    ch_a_code  = W'(a);
    ch_b_code  = W'(b);
    fmt_signed = f;
    doze       = dz;
    power_off  = po;
    drive_off  = off;
    @(posedge clk);
    if (dz || po) begin
      exp_v = 1'b0;
      fresh = 0;
    end else begin
      hist_a[run_cnt % HD] = a;
      hist_b[run_cnt % HD] = b;
      exp_v = (fresh >= LAT);
      if (run_cnt >= LAT) begin
        exp_a = to_fmt(hist_a[(run_cnt - LAT) % HD], f);
        exp_b = to_fmt(hist_b[(run_cnt - LAT) % HD], f);
      end else begin
        exp_a = to_fmt(0, f);
        exp_b = to_fmt(0, f);
      end
      run_cnt++;
      if (fresh < LAT) fresh++;
    end
    @(negedge clk);
    check(int'(bus_a) == exp_a && int'(bus_b) == exp_b && words_valid == exp_v, tag,
          (int'(bus_a) << (W + 1)) | (int'(bus_b) << 1) | int'(words_valid),
          (exp_a << (W + 1)) | (exp_b << 1) | int'(exp_v));
    check_en("R5");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(bus_a == '0 && bus_b == '0 && !words_valid, "R1",
          int'({bus_a, bus_b, words_valid}), 0);
    rst = 1'b0;

    // R2: distinct codes per channel, latency and same-edge update
    for (int i = 0; i < 12; i++) step(37 * i + 3, 900 - 61 * i, 1'b0, 1'b0, 1'b0, 1'b0, "R2");

    // R3: exhaustive offset-binary sweep, B mirrored
    for (int i = 0; i < FS; i++) step(i, FS - 1 - i, 1'b0, 1'b0, 1'b0, 1'b0, "R3");
    for (int i = 0; i < LAT; i++) step(0, 0, 1'b0, 1'b0, 1'b0, 1'b0, "R3");

    // R4: exhaustive two's-complement sweep (0, 511, 512, 1023 included)
    for (int i = 0; i < FS; i++) step(i, FS - 1 - i, 1'b1, 1'b0, 1'b0, 1'b0, "R4");
    for (int i = 0; i < LAT; i++) step(HALF, HALF - 1, 1'b1, 1'b0, 1'b0, 1'b0, "R4");
    // R4: format toggling every edge, sampled at the load edge
    for (int i = 0; i < 20; i++) step(i * 50, 1023 - i * 50, i[0], 1'b0, 1'b0, 1'b0, "R4");

    // R6: power-off pulse with bus driven, inputs keep changing
    for (int i = 0; i < 8; i++) step(100 + i, 200 + i, 1'b0, 1'b0, 1'b0, 1'b0, "R2");
    for (int i = 0; i < 8; i++)
      step(int'($urandom_range(FS - 1)), int'($urandom_range(FS - 1)), 1'b0, 1'b0, 1'b1, 1'b0, "R6");
    for (int i = 0; i < 10; i++) step(300 + i, 400 + i, 1'b0, 1'b0, 1'b0, 1'b0, "R8");

    // R7: doze pulse, bus floated during half of it
    for (int i = 0; i < 8; i++)
      step(int'($urandom_range(FS - 1)), int'($urandom_range(FS - 1)), 1'b1, 1'b1, 1'b0, i >= 4, "R7");
    for (int i = 0; i < 10; i++) step(500 + i, 600 + i, 1'b1, 1'b0, 1'b0, 1'b0, "R8");

    // R8: one-cycle stall in mid-stream
    step(7, 8, 1'b0, 1'b0, 1'b1, 1'b0, "R6");
    for (int i = 0; i < 8; i++) step(700 + i, 20 + i, 1'b0, 1'b0, 1'b0, 1'b0, "R8");

    // R5: enable reacts between clock edges
    for (int i = 0; i < 4; i++) begin
      drive_off = 1'b1;
      #0.5;
      check_en("R5");
      drive_off = 1'b0;
      #0.5;
      check_en("R5");
      @(negedge clk);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule